// File: doc/BRIEF.md
# Debug Resume-at-Address Sequencer

This block carries out the "resume at a new address" step of a debug session on a halted processor core. A debug controller issues a start command while the core is halted. It then supplies the target address one bit per qualified shift strobe. The address is absolute, arrives least significant bit first, and is `ADDR_W` bits wide (16 by default). Bits may arrive with idle cycles between them. Collection can be abandoned at any time with an abort command. An abort discards the partial address and leaves the core halted.

When the last address bit is accepted, the block does four things on the following clock edge. It loads the complete address into the program data bus register. It sends a one-cycle resume pulse to the core. It drops the halt indication and clears the debug-mode flag. The core then executes the injected jump and fetches from the target address. It keeps running until a debug-entry event halts it again, which also sets the debug-mode flag. A trace counter counts instructions while tracing is enabled. The injected jump is counted as one of those instructions, so a debugger reading the counter sees one extra count per resume.

Top module: `dbg_resume_seq`

## Requirements
- R1: After reset the block reports the following. `halted` = 1, `debug_mode` = 1, `busy` = 0, `resume_pulse` = 0, `pdb_addr` = 0 and `trace_count` = 0.
- R2: `go_cmd` starts address collection only when the core is halted and no collection is in progress. `busy` reads 1 from the next cycle. `go_cmd` has no effect while the core runs or while collection is in progress.
- R3: During collection, each cycle with `shift_en` = 1 accepts `shift_bit` as the next address bit, least significant bit first. `pdb_addr` keeps its old value until the `ADDR_W`-th bit is accepted. It holds the assembled address from the next cycle on.
- R4: `resume_pulse` is 1 for exactly one cycle, in the cycle after the final bit is accepted. In that same cycle, `halted`, `debug_mode` and `busy` read 0.
- R5: When `abort_cmd` = 1 during collection, `busy` reads 0 in the next cycle. `halted` and `debug_mode` stay 1. The partial address is discarded, so a later collection assembles only its own bits.
- R6: When `dbg_entry` = 1 while the core runs, `halted` and `debug_mode` read 1 in the next cycle. While the core is halted, `dbg_entry` has no effect.
- R7: When `trace_en` = 1 in the cycle the final address bit is accepted, `trace_count` increases by one for the injected jump.
- R8: While the core runs and `trace_en` = 1, each `core_retire` = 1 cycle increases `trace_count` by one. The counter wraps modulo 2^`TRACE_W`. When `trace_en` = 0 the counter holds its value.
- R9: `shift_en` is ignored outside collection. Strobes given while halted-idle or while running add no bits to a later address.
- R10: When `abort_cmd` and `shift_en` are both 1 in the same cycle, the abort wins and the bit is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_cmd | input | 1 | Start address collection (honoured only while halted and idle) |
| shift_en | input | 1 | Qualified shift strobe for one address bit |
| shift_bit | input | 1 | Serial address bit, least significant bit first |
| abort_cmd | input | 1 | Abandon the collection in progress |
| dbg_entry | input | 1 | Debug-mode condition that halts the running core |
| trace_en | input | 1 | Trace-mode enable |
| core_retire | input | 1 | Core retired one instruction |
| pdb_addr | output | ADDR_W | Program data bus register holding the jump target |
| resume_pulse | output | 1 | One-cycle release request to the core |
| halted | output | 1 | Core is held in the halt state |
| debug_mode | output | 1 | Debug-mode status flag |
| busy | output | 1 | Address collection in progress |
| trace_count | output | TRACE_W | Trace instruction counter |

## Verification
The bench builds the block with `ADDR_W` = 16, the full target address width. It sets `TRACE_W` = 6, so the trace counter wraps after only 64 counted instructions. A directed burst of retirements reaches the wrap, and the random runs also cross it several times. The random stimulus varies several things: the addresses, the idle gaps between bits, aborts at random bit positions (some coinciding with a strobe), stray strobes and start commands while running, and the trace enable. Together these reach the final-bit release, the abort path and the joint counting of the jump and retirements.

// File: rtl/dbg_resume_pkg.sv
package dbg_resume_pkg;

  typedef enum logic [1:0] {
    SEQ_RUN     = 2'd0,
    SEQ_HALT    = 2'd1,
    SEQ_COLLECT = 2'd2
  } seq_state_e;

endpackage

// File: rtl/rs_addr_collector.sv
module rs_addr_collector #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift_q,
  input  logic              shift_bit,
  output logic              last_bit,
  output logic [ADDR_W-1:0] addr_full
);

  localparam int CNT_W = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_W - 1);

  logic [ADDR_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              sh_en;

  // new bit enters at the top and moves down: first bit ends at bit 0
  always_comb begin
    addr_full = {shift_bit, sh_q[ADDR_W-1:1]};
    last_bit  = shift_q && (cnt_q == LAST_IDX);
  end

  always_comb begin
    sh_en = clear || shift_q;
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (clear || last_bit) begin
      sh_d  = '0;
      cnt_d = '0;
    end else if (shift_q) begin
      sh_d  = addr_full;
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (sh_en) begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/rs_ctrl.sv
module rs_ctrl
  import dbg_resume_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go_cmd,
  input  logic abort_cmd,
  input  logic shift_en,
  input  logic last_bit,
  input  logic dbg_entry,
  output logic shift_q,
  output logic clear,
  output logic load,
  output logic busy,
  output logic halted,
  output logic debug_mode,
  output logic resume_pulse
);

  seq_state_e state_q, state_d;
  logic       dbg_q, dbg_d;
  logic       res_q, res_d;

  always_comb begin
    shift_q = (state_q == SEQ_COLLECT) && shift_en && !abort_cmd;
    clear   = ((state_q == SEQ_HALT) && go_cmd) ||
              ((state_q == SEQ_COLLECT) && abort_cmd);
    load    = last_bit;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_RUN:     if (dbg_entry) state_d = SEQ_HALT;
      SEQ_HALT:    if (go_cmd)    state_d = SEQ_COLLECT;
      SEQ_COLLECT: begin
        if (abort_cmd)     state_d = SEQ_HALT;
        else if (last_bit) state_d = SEQ_RUN;
      end
      default:               state_d = SEQ_HALT;
    endcase
  end

  always_comb begin
    dbg_d = dbg_q;
    if (load)                                     dbg_d = 1'b0;
    else if ((state_q == SEQ_RUN) && dbg_entry)   dbg_d = 1'b1;
    res_d = load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_HALT;
      dbg_q   <= 1'b1;
      res_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      dbg_q   <= dbg_d;
      res_q   <= res_d;
    end
  end

  always_comb begin
    busy         = (state_q == SEQ_COLLECT);
    halted       = (state_q != SEQ_RUN);
    debug_mode   = dbg_q;
    resume_pulse = res_q;
  end

  // R4
  resume_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |=> !resume_pulse);

  // R4
  resume_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |-> (!halted && !debug_mode && !busy));

  // R5
  abort_keeps_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && abort_cmd) |=> (halted && debug_mode && !busy));

  // R6
  reenter_debug_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && dbg_entry) |=> (halted && debug_mode));

  // R2
  go_while_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && !dbg_entry) |=> !busy);

endmodule

// File: rtl/rs_trace_counter.sv
module rs_trace_counter #(
  parameter int TRACE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trace_en,
  input  logic               jump_evt,
  input  logic               retire_evt,
  output logic [TRACE_W-1:0] count
);

  logic [TRACE_W-1:0] cnt_q, cnt_d;
  logic               cnt_en;

  always_comb begin
    cnt_en = trace_en && (jump_evt || retire_evt);
    cnt_d  = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R8
  trace_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trace_en |=> $stable(count));

endmodule

// File: rtl/dbg_resume_seq.sv
module dbg_resume_seq #(
  parameter int ADDR_W  = 16,
  parameter int TRACE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go_cmd,
  input  logic               shift_en,
  input  logic               shift_bit,
  input  logic               abort_cmd,
  input  logic               dbg_entry,
  input  logic               trace_en,
  input  logic               core_retire,
  output logic [ADDR_W-1:0]  pdb_addr,
  output logic               resume_pulse,
  output logic               halted,
  output logic               debug_mode,
  output logic               busy,
  output logic [TRACE_W-1:0] trace_count
);

  logic              shift_q, clear, load, last_bit;
  logic [ADDR_W-1:0] addr_full;
  logic [ADDR_W-1:0] pdb_q;

  rs_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .go_cmd       (go_cmd),
    .abort_cmd    (abort_cmd),
    .shift_en     (shift_en),
    .last_bit     (last_bit),
    .dbg_entry    (dbg_entry),
    .shift_q      (shift_q),
    .clear        (clear),
    .load         (load),
    .busy         (busy),
    .halted       (halted),
    .debug_mode   (debug_mode),
    .resume_pulse (resume_pulse)
  );

  rs_addr_collector #(.ADDR_W(ADDR_W)) u_coll (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .shift_q   (shift_q),
    .shift_bit (shift_bit),
    .last_bit  (last_bit),
    .addr_full (addr_full)
  );

  rs_trace_counter #(.TRACE_W(TRACE_W)) u_trace (
    .clk        (clk),
    .rst_n      (rst_n),
    .trace_en   (trace_en),
    .jump_evt   (load),
    .retire_evt (core_retire && !halted),
    .count      (trace_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pdb_q <= '0;
    else if (load) pdb_q <= addr_full;
  end

  assign pdb_addr = pdb_q;

  // R3
  pdb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !resume_pulse |-> $stable(pdb_addr));

  // R9
  idle_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !go_cmd) |=> !busy);

endmodule

// File: tb/dbg_resume_seq_test.sv
module dbg_resume_seq_test;

  localparam int PERIOD = 10;
  localparam int AW     = 16;
  localparam int TW     = 6;
  localparam int TMASK  = (1 << TW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          go_cmd, shift_en, shift_bit, abort_cmd, dbg_entry, trace_en, core_retire;
  logic [AW-1:0] pdb_addr;
  logic          resume_pulse, halted, debug_mode, busy;
  logic [TW-1:0] trace_count;

  int n_chk = 0;
  int n_bad = 0;
  int exp_trace = 0;
  logic [AW-1:0] exp_pdb = '0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  dbg_resume_seq #(.ADDR_W(AW), .TRACE_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .go_cmd(go_cmd), .shift_en(shift_en),
    .shift_bit(shift_bit), .abort_cmd(abort_cmd), .dbg_entry(dbg_entry),
    .trace_en(trace_en), .core_retire(core_retire), .pdb_addr(pdb_addr),
    .resume_pulse(resume_pulse), .halted(halted), .debug_mode(debug_mode),
    .busy(busy), .trace_count(trace_count)
  );

  function automatic int bump(input int v);
    return (v + 1) & TMASK;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic quiet();
    go_cmd = 0; shift_en = 0; shift_bit = 0; abort_cmd = 0; dbg_entry = 0; core_retire = 0;
  endtask

  // abort_at < 0: full transfer; abort_with_shift raises shift_en together with abort
  task automatic send_addr(input logic [AW-1:0] a, input int abort_at, input bit abort_with_shift);
    go_cmd = 1; tick(); go_cmd = 0;
    chk("R2 busy after go", busy, 1);
    for (int i = 0; i < AW; i++) begin
      if ($urandom % 4 == 0) begin
        shift_en = 0; shift_bit = 1'($urandom); tick();
      end
      if (i == abort_at) begin
        abort_cmd = 1; shift_en = abort_with_shift; shift_bit = a[i]; tick();
        abort_cmd = 0; shift_en = 0;
        chk("R5 busy after abort", busy, 0);
        chk("R5 halted after abort", halted, 1);
        chk("R5 debug after abort", debug_mode, 1);
        chk("R10 pdb after abort", pdb_addr, exp_pdb);
        return;
      end
      shift_en = 1; shift_bit = a[i]; tick(); shift_en = 0;
      if (i < AW - 1) begin
        chk("R4 no early resume", resume_pulse, 0);
        chk("R3 pdb held", pdb_addr, exp_pdb);
      end else begin
        if (trace_en) exp_trace = bump(exp_trace);
        exp_pdb = a;
        chk("R3 pdb loaded", pdb_addr, a);
        chk("R4 resume pulse", resume_pulse, 1);
        chk("R4 halted clear", halted, 0);
        chk("R4 debug clear", debug_mode, 0);
        chk("R7 trace jump", trace_count, exp_trace);
      end
    end
    tick();
    chk("R4 pulse single", resume_pulse, 0);
  endtask

  task automatic run_phase(input int n);
    for (int k = 0; k < n; k++) begin
      core_retire = 1'($urandom);
      go_cmd      = ($urandom % 4 == 0);
      shift_en    = 1'($urandom);
      shift_bit   = 1'($urandom);
      tick();
      if (core_retire && trace_en) exp_trace = bump(exp_trace);
      quiet();
      chk("R2 go ignored running", busy, 0);
      chk("R8 trace retire", trace_count, exp_trace);
    end
    dbg_entry = 1; tick(); dbg_entry = 0;
    chk("R6 halted on entry", halted, 1);
    chk("R6 debug on entry", debug_mode, 1);
    dbg_entry = 1; shift_en = 1; tick(); quiet();
    chk("R6 entry while halted", halted, 1);
    chk("R9 no collect while halted", busy, 0);
  endtask

  initial begin
    #(PERIOD * 190000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1437));
    quiet(); trace_en = 0; rst_n = 0;
    repeat (3) tick();
    rst_n = 1; tick();
    // R1
    chk("R1 halted", halted, 1);
    chk("R1 debug", debug_mode, 1);
    chk("R1 busy", busy, 0);
    chk("R1 resume", resume_pulse, 0);
    chk("R1 pdb", pdb_addr, 0);
    chk("R1 trace", trace_count, 0);

    // R9 stray strobes before go must not leave residue
    repeat (5) begin shift_en = 1; shift_bit = 1; tick(); end
    quiet();
    chk("R9 busy idle", busy, 0);
    trace_en = 1;
    send_addr(16'h0001, -1, 0);
    run_phase(4);

    // R10 abort and strobe together, then clean transfer
    send_addr(16'hFFFF, 7, 1);
    send_addr(16'h8000, -1, 0);
    run_phase(3);

    // R2 go while collecting does not restart
    go_cmd = 1; tick(); go_cmd = 0;
    for (int i = 0; i < AW; i++) begin
      go_cmd = (i == 3); shift_en = 1; shift_bit = (i % 3 == 0); tick(); quiet();
    end
    if (trace_en) exp_trace = bump(exp_trace);
    exp_pdb = 16'h9249;
    chk("R2 go mid-collect ignored", pdb_addr, 16'h9249);
    chk("R2 resumed", halted, 0);
    run_phase(2);

    // R8 wrap of the trace counter
    trace_en = 1;
    send_addr(16'h1234, -1, 0);
    for (int k = 0; k < 70; k++) begin
      core_retire = 1; tick(); exp_trace = bump(exp_trace);
    end
    quiet();
    chk("R8 trace wrap", trace_count, exp_trace);
    trace_en = 0;
    run_phase(5);

    for (int t = 0; t < 40; t++) begin
      logic [AW-1:0] a;
      a = AW'($urandom);
      trace_en = 1'($urandom);
      if ($urandom % 3 == 0) send_addr(AW'($urandom), int'($urandom % AW), 1'($urandom));
      send_addr(a, -1, 0);
      trace_en = 1'($urandom);
      run_phase(3 + int'($urandom % 10));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule